// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a small data cache placed between a processor load/store port and a word-addressed backing memory. Each line holds one data word together with a valid flag, a modified (dirty) flag and an address tag. The low address bits choose the line and the remaining high bits are compared with the stored tag. Loads and stores that hit are served from the line and do not touch memory. Stores mark the line modified. A modified word goes back to memory only when a later miss to the same line evicts it.

The processor raises a request with an address, a write flag and write data. It must hold all of these until a one-cycle done pulse returns, and only one request is in flight at a time. On a miss, the controller first writes the victim back if it is dirty, then reads the wanted word. The memory side is a request/acknowledge handshake with any latency. Two counters report completed requests and how many of them hit.

Top module: `dm_wb_cache`

## Requirements
- R1: The line index is the lowest IDX_W address bits and the tag is the remaining upper bits; with a 5-bit address and 4 lines the index is addr[1:0] and the tag is addr[4:2].
- R2: After reset all lines are invalid, both counters read zero, cpu_done is low and mem_req is low.
- R3: A request hits only when the indexed line is valid and its stored tag equals the request tag; otherwise it misses.
- R4: A load hit returns the cached word on cpu_rdata with cpu_done and issues no memory transaction.
- R5: A load miss to a clean or invalid line performs exactly one memory read (mem_we=0) at the request address, returns mem_rdata and installs the line valid and clean with the new tag.
- R6: A store hit replaces the cached word and marks the line dirty without any memory transaction; a later load of that address returns the stored data.
- R7: A store miss first reads the line from memory, then merges the store data and marks the line dirty; memory is not written by the store itself.
- R8: Evicting a dirty line writes its word to memory at {old tag, index} (mem_we=1), and this write is acknowledged before the fill read is issued; the fill read is requested in the cycle right after the writeback acknowledge. A clean victim is dropped without a write.
- R9: access_count increments by one on every completed request and hit_count only on hits; both clear on reset.
- R10: Loads to 01010, 01100, 01010, 11010, 01010 from reset give miss, miss, hit, miss, miss.
- R11: Once mem_req is raised it stays high with stable mem_addr and mem_we until mem_ack; any latency is accepted.
- R12: cpu_done is a single-cycle pulse per request, and cpu_rdata holds the loaded word while cpu_done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Request, held until cpu_done |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_done |
| cpu_done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 = writeback, 0 = fill read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Writeback data |
| mem_rdata | input | DATA_W | Fill data, valid with mem_ack |
| mem_ack | input | 1 | Memory completion pulse |
| hit_count | output | CNT_W | Number of hits |
| access_count | output | CNT_W | Number of completed requests |

## Verification
The writeback acknowledge and the issue of the fill read share one clock edge. When the memory answers the writeback of a dirty victim, the controller must switch to the fill address on the next cycle and must not issue the two in the other order. The bench provokes this by evicting dirty lines with the memory latency set to zero and to a nonzero value. It then judges from a log of memory operations kept by the memory model that the write to the old address came first and the read of the new address came second. An assertion also requires the read request in the cycle right after the write acknowledge.

// File: rtl/dm_cache_pkg.sv
// Package: shared controller state encoding for the direct-mapped cache.
package dm_cache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a processor request
        ST_LOOK,   // compare tag of the indexed line
        ST_WBACK,  // writing dirty victim to memory
        ST_FILL,   // reading requested word from memory
        ST_DONE    // one-cycle completion pulse
    } cache_state_t;
endpackage

// File: rtl/dm_line_store.sv
// Module: line storage of the cache. One register set per line (valid,
// dirty, tag, data) built by a generate loop, with one combinational read
// port and one write port sharing the same index.
// Assumes: a write always makes the line valid; reset clears valid and dirty.
module dm_line_store #(
    parameter int LINES  = 4,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_dirty,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data
);
    logic [LINES-1:0]  valid_q;
    logic [LINES-1:0]  dirty_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Per-line state update on a write addressed to this line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                dirty_q[g] <= 1'b0;
                tag_q[g]   <= '0;
                data_q[g]  <= '0;
            end else if (wr_en && (idx == IDX_W'(g))) begin
                valid_q[g] <= 1'b1;
                dirty_q[g] <= wr_dirty;
                tag_q[g]   <= wr_tag;
                data_q[g]  <= wr_data;
            end
        end
    end

    // Read port: contents of the indexed line.
    always_comb begin
        rd_valid = valid_q[idx];
        rd_dirty = dirty_q[idx];
        rd_tag   = tag_q[idx];
        rd_data  = data_q[idx];
    end
endmodule

// File: rtl/dm_cache_ctrl.sv
// Module: miss/hit controller. Looks up the indexed line, serves hits,
// writes back a dirty victim, fills from memory and merges stores.
// Assumes: the processor holds cpu_* until cpu_done; memory holds mem_rdata
// valid while mem_ack is high and acknowledges each request once.
module dm_cache_ctrl
    import dm_cache_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int LINES  = 4,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              ln_valid,
    input  logic              ln_dirty,
    input  logic [TAG_W-1:0]  ln_tag,
    input  logic [DATA_W-1:0] ln_data,
    output logic              wr_en,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_dirty,
    output logic              hit_pulse,
    output logic              acc_pulse
);
    cache_state_t        state_q, state_d;
    logic [DATA_W-1:0]   rdata_q;
    logic [IDX_W-1:0]    req_idx;
    logic [TAG_W-1:0]    req_tag;
    logic                hit;

    assign req_idx = cpu_addr[IDX_W-1:0];
    assign req_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign hit     = ln_valid && (ln_tag == req_tag);

    // Next-state and line write decisions.
    always_comb begin
        state_d   = state_q;
        wr_en     = 1'b0;
        wr_tag    = req_tag;
        wr_data   = cpu_wdata;
        wr_dirty  = 1'b0;
        hit_pulse = 1'b0;
        acc_pulse = 1'b0;
        unique case (state_q)
            ST_IDLE: if (cpu_req) state_d = ST_LOOK;
            ST_LOOK: begin
                if (hit) begin
                    state_d   = ST_DONE;
                    wr_en     = cpu_we;
                    wr_dirty  = 1'b1;
                    hit_pulse = 1'b1;
                    acc_pulse = 1'b1;
                end else if (ln_valid && ln_dirty) begin
                    state_d = ST_WBACK;
                end else begin
                    state_d = ST_FILL;
                end
            end
            ST_WBACK: if (mem_ack) state_d = ST_FILL;
            ST_FILL: begin
                if (mem_ack) begin
                    state_d   = ST_DONE;
                    wr_en     = 1'b1;
                    wr_data   = cpu_we ? cpu_wdata : mem_rdata;
                    wr_dirty  = cpu_we;
                    acc_pulse = 1'b1;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Load data capture from a hit or from the fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (state_q == ST_LOOK && hit && !cpu_we) begin
            rdata_q <= ln_data;
        end else if (state_q == ST_FILL && mem_ack && !cpu_we) begin
            rdata_q <= mem_rdata;
        end
    end

    // Memory-side and processor-side outputs decoded from state.
    always_comb begin
        cpu_rdata = rdata_q;
        cpu_done  = (state_q == ST_DONE);
        mem_req   = (state_q == ST_WBACK) || (state_q == ST_FILL);
        mem_we    = (state_q == ST_WBACK);
        mem_addr  = (state_q == ST_WBACK) ? {ln_tag, req_idx} : cpu_addr;
        mem_wdata = ln_data;
    end
endmodule

// File: rtl/dm_cache_counters.sv
// Module: access and hit counters. Wrap silently at CNT_W bits.
// Assumes: hit_pulse is only high together with acc_pulse.
module dm_cache_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_pulse,
    input  logic             acc_pulse,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] access_count
);
    // Count completed requests and hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_count    <= '0;
            access_count <= '0;
        end else begin
            if (hit_pulse) hit_count    <= hit_count + 1'b1;
            if (acc_pulse) access_count <= access_count + 1'b1;
        end
    end
endmodule

// File: rtl/dm_wb_cache.sv
// Module: top of the direct-mapped write-back data cache. Connects line
// storage, controller and counters.
// Assumes: one outstanding processor request; word-addressed memory.
module dm_wb_cache #(
    parameter int ADDR_W = 5,
    parameter int LINES  = 4,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  access_count
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic              ln_valid, ln_dirty, wr_en, wr_dirty;
    logic [TAG_W-1:0]  ln_tag, wr_tag;
    logic [DATA_W-1:0] ln_data, wr_data;
    logic              hit_pulse, acc_pulse;

    dm_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .idx(cpu_addr[IDX_W-1:0]),
        .wr_en(wr_en), .wr_tag(wr_tag), .wr_data(wr_data), .wr_dirty(wr_dirty),
        .rd_valid(ln_valid), .rd_dirty(ln_dirty), .rd_tag(ln_tag), .rd_data(ln_data)
    );

    dm_cache_ctrl #(.ADDR_W(ADDR_W), .LINES(LINES), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .ln_valid(ln_valid), .ln_dirty(ln_dirty), .ln_tag(ln_tag), .ln_data(ln_data),
        .wr_en(wr_en), .wr_tag(wr_tag), .wr_data(wr_data), .wr_dirty(wr_dirty),
        .hit_pulse(hit_pulse), .acc_pulse(acc_pulse)
    );

    dm_cache_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .hit_pulse(hit_pulse), .acc_pulse(acc_pulse),
        .hit_count(hit_count), .access_count(access_count)
    );
endmodule

// File: rtl/dm_wb_cache_checker.sv
// Module: protocol and counter properties for dm_wb_cache, bound to the top.
module dm_wb_cache_checker #(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_done,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic [CNT_W-1:0]  hit_count,
    input logic [CNT_W-1:0]  access_count
);
    // R11: a pending memory request stays put until acknowledged.
    p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R8: fill read follows the writeback acknowledge in the next cycle.
    p_wb_then_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    // R12: completion is a single-cycle pulse.
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R9: each completion advances the access count by exactly one.
    p_acc_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_done) |-> (access_count == $past(access_count) + 1'b1));

    // R4: a hit is counted only when no memory request was active.
    p_hit_no_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_count != $past(hit_count)) |-> !$past(mem_req));

    // R9: hits never outnumber completed requests.
    p_hit_le_acc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_count <= access_count);
endmodule

bind dm_wb_cache dm_wb_cache_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_checker (
    .clk(clk), .rst_n(rst_n), .cpu_done(cpu_done), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .hit_count(hit_count), .access_count(access_count)
);

// File: tb/test_dm_wb_cache.sv
module test_dm_wb_cache;
    localparam int AW = 5;
    localparam int DW = 16;
    localparam int CW = 16;
    localparam int NV = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_done;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_ack = 1'b0;
    logic [CW-1:0] hit_count, access_count;

    int total = 0, bad = 0;
    int lat = 0, wait_cnt = 0, n_rd = 0, n_wr = 0, n_log = 0;
    logic [DW-1:0] mem [32];
    logic          log_we   [16];
    logic [AW-1:0] log_addr [16];
    logic [DW-1:0] log_data [16];

    always #2 clk = ~clk;  // 250 MHz

    dm_wb_cache #(.ADDR_W(AW), .LINES(4), .DATA_W(DW), .CNT_W(CW)) i_dm_wb_cache (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_done(cpu_done), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .hit_count(hit_count), .access_count(access_count)
    );

    // Backing memory model with programmable latency and an operation log.
    initial begin
        for (int i = 0; i < 32; i++) mem[i] = 16'h5A00 + 16'(i);
        forever begin
            @(posedge clk);
            if (!rst_n) begin
                mem_ack <= 1'b0; wait_cnt = 0;
            end else if (mem_ack) begin
                mem_ack <= 1'b0;
            end else if (mem_req) begin
                if (wait_cnt >= lat) begin
                    wait_cnt = 0;
                    mem_ack <= 1'b1;
                    if (n_log < 16) begin
                        log_we[n_log] = mem_we; log_addr[n_log] = mem_addr;
                        log_data[n_log] = mem_wdata; n_log++;
                    end
                    if (mem_we) begin mem[mem_addr] = mem_wdata; n_wr++; end
                    else begin mem_rdata <= mem[mem_addr]; n_rd++; end
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [DW-1:0] got;
    task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        do @(negedge clk); while (!cpu_done);
        got = cpu_rdata;
        cpu_req = 1'b0;
    endtask

    // Vector: we, addr, wdata, expected rdata, expected hit, reads, writes.
    localparam logic [42:0] VEC [NV] = '{
        {1'b0, 5'b01010, 16'h0000, 16'h5A0A, 1'b0, 2'd1, 2'd0},
        {1'b0, 5'b01100, 16'h0000, 16'h5A0C, 1'b0, 2'd1, 2'd0},
        {1'b0, 5'b01010, 16'h0000, 16'h5A0A, 1'b1, 2'd0, 2'd0},
        {1'b0, 5'b11010, 16'h0000, 16'h5A1A, 1'b0, 2'd1, 2'd0},
        {1'b0, 5'b01010, 16'h0000, 16'h5A0A, 1'b0, 2'd1, 2'd0},
        {1'b1, 5'b01010, 16'hBEEF, 16'h0000, 1'b1, 2'd0, 2'd0},
        {1'b0, 5'b01010, 16'h0000, 16'hBEEF, 1'b1, 2'd0, 2'd0},
        {1'b1, 5'b00111, 16'h1234, 16'h0000, 1'b0, 2'd1, 2'd0},
        {1'b0, 5'b00111, 16'h0000, 16'h1234, 1'b1, 2'd0, 2'd0},
        {1'b0, 5'b11110, 16'h0000, 16'h5A1E, 1'b0, 2'd1, 2'd1},
        {1'b0, 5'b01010, 16'h0000, 16'hBEEF, 1'b0, 2'd1, 2'd0},
        {1'b0, 5'b01100, 16'h0000, 16'h5A0C, 1'b1, 2'd0, 2'd0}
    };

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int h0, r0, w0, l0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2: reset state
        check(hit_count == 0 && access_count == 0, "R2 counters", hit_count, 0);
        check(!cpu_done && !mem_req, "R2 idle outputs", {cpu_done, mem_req}, 0);
        rst_n = 1'b1;

        // Table walk: R1 R3 R4 R5 R6 R7 R10 (first five are the R10 sequence).
        for (int i = 0; i < NV; i++) begin
            lat = i % 4;
            h0 = hit_count; r0 = n_rd; w0 = n_wr; l0 = n_log;
            access(VEC[i][42], VEC[i][41:37], VEC[i][36:21]);
            if (!VEC[i][42])
                check(got == VEC[i][20:5], $sformatf("R5 R4 rdata vec%0d", i), got, VEC[i][20:5]);
            check((hit_count - h0) == int'(VEC[i][4]), $sformatf("R3 R10 hit vec%0d", i),
                  hit_count - h0, VEC[i][4]);
            check((n_rd - r0) == int'(VEC[i][3:2]) && (n_wr - w0) == int'(VEC[i][1:0]),
                  $sformatf("R6 R7 mem traffic vec%0d", i), (n_rd - r0) * 16 + (n_wr - w0),
                  VEC[i][3:2] * 16 + VEC[i][1:0]);
            if (i == 9) begin
                // R8: writeback of 01010 (BEEF) logged before fill of 11110
                check(log_we[l0] && log_addr[l0] == 5'b01010 && log_data[l0] == 16'hBEEF,
                      "R8 writeback first", log_addr[l0], 5'b01010);
                check(!log_we[l0+1] && log_addr[l0+1] == 5'b11110, "R8 fill second",
                      log_addr[l0+1], 5'b11110);
            end
        end
        check(access_count == NV, "R9 access count", access_count, NV);
        check(hit_count == 5, "R9 hit count", hit_count, 5);
        // R7: dirty store-miss line not yet in memory
        check(mem[7] == 16'h5A07, "R7 no write before eviction", mem[7], 16'h5A07);

        // R8: zero-latency dirty eviction of index 3 by 10111
        lat = 0; l0 = n_log;
        access(1'b0, 5'b10111, '0);
        check(got == 16'h5A17, "R8 fill data", got, 16'h5A17);
        check(mem[7] == 16'h1234, "R8 writeback data", mem[7], 16'h1234);
        check(log_we[l0] && log_addr[l0] == 5'b00111 && !log_we[l0+1] && log_addr[l0+1] == 5'b10111,
              "R8 order at lat0", log_addr[l0+1], 5'b10111);
        // R12: done dropped the cycle after
        @(negedge clk);
        check(!cpu_done, "R12 done pulse", cpu_done, 0);

        // R2 R9: reset mid-run clears lines and counters
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check(hit_count == 0 && access_count == 0, "R2 R9 counters after reset", access_count, 0);
        rst_n = 1'b1;
        r0 = n_rd;
        access(1'b0, 5'b01100, '0);
        check(hit_count == 0 && (n_rd - r0) == 1, "R2 line invalid after reset", hit_count, 0);
        check(access_count == 1 && got == 16'h5A0C, "R9 R1 after reset", got, 16'h5A0C);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule